// File: doc/BRIEF.md
# Fractional-N Feedback Modulus Controller

This block supplies the feedback divide value of a fractional-N frequency synthesizer, one value per reference cycle. It combines an integer divide value with a 20-bit fraction. A two-stage cascaded sigma-delta modulator (MASH 1-1) dithers the integer, so the long-run mean of the issued values is the integer plus the fraction divided by 2^20. Each issued value lies between one below and two above the integer. Software-style settings arrive as byte writes on a small write port. The integer and the fraction wait in shadow registers and reach the modulator together when the lowest fraction byte is written. The divider therefore never runs with a half-updated ratio. The block also holds two divider selects: the reference pre-divider (divide by 1 or 2) and the LO output divider (divide by 4, 8, 16 or 32).

The modulus leaves on a valid/ready stream. After reset, `mod_valid` stays high. The multi-modulus divider raises `mod_ready` in each reference cycle in which it loads a new modulus. A value counts as accepted on a clock edge where both are high, and only an accepted value moves the modulator forward. While `mod_ready` is low, the modulator state is frozen and `mod_data` holds, so back-pressure never loses or repeats a dither step. The one exception is a commit, which may change the offered value while it is waiting.

Top module: `fnm_modulus_ctrl`

## Requirements
- R1: While reset is asserted, `mod_valid` is low. From the first clock edge after reset is released, `mod_valid` is high and stays high. At that point `mod_data` is 19, `int_clamped` is 0, `ref_div_factor` is 1 and `lo_div_log2` is 2.
- R2: The `wr_sel` codes are decoded as follows, and writes with codes 5 to 7 change nothing.
  - 0: integer value.
  - 1: bits 3:0 carry fraction bits 19:16, and bits 5:4 carry the reference divider code.
  - 2: fraction bits 15:8.
  - 3: fraction bits 7:0, and this write is the commit.
  - 4: bits 1:0 carry the LO divider code.
- R3: Writes with codes 0, 1 and 2 leave the integer and fraction used by the modulator unchanged. A code 3 write loads the pending integer and the full 20-bit fraction on the same clock edge.
- R4: `mod_data` is N + c1 + c2 − c2p, where the terms are defined as follows.
  - c1 is the carry out of 20-bit accumulator A1 plus the fraction F.
  - c2 is the carry out of 20-bit accumulator A2 plus the new A1 residue.
  - c2p is c2 as it was at the previous acceptance.
  - On acceptance, A1 and A2 take their residues.
  - All three terms are zero after reset.
- R5: While valid, `mod_data` is within N−1 to N+2, where N is the clamped integer.
- R6: The modulator state advances only on an accepted value. With `mod_ready` low and no commit, `mod_data` is stable.
- R7: After reset, commit N and F, where F is a multiple of 256, before any acceptance. The next 4096 accepted values then sum to N·4096 + F/256 + k, where k is 0 or 1.
- R8: A committed integer below 19 is used as 19, and one above 251 is used as 251. `int_clamped` is high exactly while the committed raw integer lies outside 19 to 251.
- R9: `ref_div_factor` takes effect on the edge of the code 1 write. Code 01 gives 2; codes 00, 10 and 11 give 1. This setting needs no commit.
- R10: `lo_div_log2` is 2 plus the LO code: 00 gives 2, 01 gives 3, 10 gives 4 and 11 gives 5. It takes effect on the edge of the code 4 write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 3 | Field select of the write |
| wr_data | input | 8 | Write byte |
| mod_ready | input | 1 | Divider accepts the offered modulus |
| mod_valid | output | 1 | Modulus offered |
| mod_data | output | 8 | Instantaneous feedback modulus |
| int_clamped | output | 1 | Committed integer was out of range and is clamped |
| ref_div_factor | output | 2 | Reference pre-divide ratio (1 or 2) |
| lo_div_log2 | output | 3 | Log2 of LO divide ratio (2 to 5) |

## Verification
The bench drives partial updates of the fraction and then checks that the modulator output does not move until the low byte is written. A design that loaded fields one at a time would run briefly with a mixed ratio and diverge from the model. It holds `mod_ready` low for long stretches and also toggles it every cycle. A modulator that stepped on every clock would then drift away from the accepted-value sequence. It commits integers below 19, at 19, at 251 and above 251; an unclamped or off-by-one clamp shows up as a wrong modulus or a wrong flag. Finally, it sums 4096 accepted values against the exact expected total. That catches a wrong carry combination or a missing differencing delay, which would bias the mean.

// File: rtl/fnm_pkg.sv
package fnm_pkg;

  localparam int INT_W      = 8;
  localparam int BYTE_W     = 8;
  localparam int FRAC_W     = 20;
  localparam int HI_W       = FRAC_W - 2 * BYTE_W;
  localparam int MASH_ORDER = 2;

  typedef enum logic [2:0] {
    SEL_INT      = 3'd0,
    SEL_FRAC_HI  = 3'd1,
    SEL_FRAC_MID = 3'd2,
    SEL_FRAC_LO  = 3'd3,
    SEL_LO_DIV   = 3'd4
  } fnm_sel_e;

  // reference pre-divider: only code 01 halves, reserved codes fall back to 1
  function automatic logic [1:0] ref_factor(input logic [1:0] code);
    return (code == 2'b01) ? 2'd2 : 2'd1;
  endfunction

  // LO divider ratio as a power of two: 4, 8, 16, 32
  function automatic logic [2:0] lo_log2(input logic [1:0] code);
    return 3'd2 + {1'b0, code};
  endfunction

endpackage

// File: rtl/fnm_regs.sv
module fnm_regs
  import fnm_pkg::*;
#(
  parameter int N_MIN = 19,
  parameter int N_MAX = 251,
  parameter int N_RST = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [INT_W-1:0]  n_eff,
  output logic [FRAC_W-1:0] frac_work,
  output logic              int_clamped,
  output logic              commit,
  output logic [1:0]        ref_div_factor,
  output logic [2:0]        lo_div_log2
);

  localparam logic [INT_W-1:0] NMIN_V = INT_W'(N_MIN);
  localparam logic [INT_W-1:0] NMAX_V = INT_W'(N_MAX);
  localparam logic [INT_W-1:0] NRST_V = INT_W'(N_RST);

  logic [INT_W-1:0]  int_sh;
  logic [INT_W-1:0]  n_raw;
  logic [HI_W-1:0]   hi_sh;
  logic [BYTE_W-1:0] mid_sh;
  logic [1:0]        ref_code;
  logic [1:0]        lo_code;

  logic hit_int, hit_hi, hit_mid, hit_lodiv;

  assign hit_int   = wr_en && (wr_sel == SEL_INT);
  assign hit_hi    = wr_en && (wr_sel == SEL_FRAC_HI);
  assign hit_mid   = wr_en && (wr_sel == SEL_FRAC_MID);
  assign commit    = wr_en && (wr_sel == SEL_FRAC_LO);
  assign hit_lodiv = wr_en && (wr_sel == SEL_LO_DIV);

  // shadow fields wait for the commit; divider selects act at once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_sh    <= NRST_V;
      n_raw     <= NRST_V;
      hi_sh     <= '0;
      mid_sh    <= '0;
      frac_work <= '0;
      ref_code  <= 2'b00;
      lo_code   <= 2'b00;
    end else begin
      if (hit_int) int_sh <= wr_data[INT_W-1:0];
      if (hit_hi) begin
        hi_sh    <= wr_data[HI_W-1:0];
        ref_code <= wr_data[HI_W+1:HI_W];
      end
      if (hit_mid) mid_sh <= wr_data;
      if (commit) begin
        frac_work <= {hi_sh, mid_sh, wr_data};
        n_raw     <= int_sh;
      end
      if (hit_lodiv) lo_code <= wr_data[1:0];
    end
  end

  always_comb begin
    if (n_raw < NMIN_V)      n_eff = NMIN_V;
    else if (n_raw > NMAX_V) n_eff = NMAX_V;
    else                     n_eff = n_raw;
  end

  assign int_clamped    = (n_raw < NMIN_V) || (n_raw > NMAX_V);
  assign ref_div_factor = ref_factor(ref_code);
  assign lo_div_log2    = lo_log2(lo_code);

  p_partial_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(frac_work) && $stable(n_eff)))
    else $error("fraction or integer moved without a commit");

  p_clamp_bounds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (n_eff >= NMIN_V) && (n_eff <= NMAX_V))
    else $error("effective integer outside legal range");

  p_clamp_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int_clamped |-> ((n_eff == NMIN_V) || (n_eff == NMAX_V)))
    else $error("clamp flag set but integer not at a bound");

  p_ref_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_div_factor == 2'd1) || (ref_div_factor == 2'd2))
    else $error("reference factor not 1 or 2");

endmodule

// File: rtl/fnm_mash.sv
module fnm_mash
  import fnm_pkg::*;
#(
  parameter int STAGES = MASH_ORDER
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [FRAC_W-1:0] frac,
  output logic [STAGES-1:0] carry
);

  logic [FRAC_W-1:0] acc  [STAGES];
  logic [FRAC_W-1:0] res  [STAGES];
  logic [FRAC_W-1:0] feed [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign feed[g] = frac;
    end else begin : g_tail
      assign feed[g] = res[g-1];
    end

    assign {carry[g], res[g]} = {1'b0, acc[g]} + {1'b0, feed[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc[g] <= '0;
      else if (adv) acc[g] <= res[g];
    end

    p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(acc[g]))
      else $error("accumulator moved without an acceptance");
  end

endmodule

// File: rtl/fnm_shaper.sv
module fnm_shaper
  import fnm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [INT_W-1:0] n_eff,
  input  logic [1:0]       carry,
  output logic [INT_W-1:0] mod_data
);

  logic c2_d;

  // first carry passes straight, second is differenced once
  assign mod_data = n_eff + INT_W'(carry[0]) + INT_W'(carry[1]) - INT_W'(c2_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   c2_d <= 1'b0;
    else if (adv) c2_d <= carry[1];
  end

  p_diff_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(c2_d))
    else $error("difference tap moved without an acceptance");

endmodule

// File: rtl/fnm_modulus_ctrl.sv
module fnm_modulus_ctrl
  import fnm_pkg::*;
#(
  parameter int N_MIN = 19,
  parameter int N_MAX = 251,
  parameter int N_RST = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic        mod_ready,
  output logic        mod_valid,
  output logic [7:0]  mod_data,
  output logic        int_clamped,
  output logic [1:0]  ref_div_factor,
  output logic [2:0]  lo_div_log2
);

  logic [INT_W-1:0]      n_eff;
  logic [FRAC_W-1:0]     frac_work;
  logic                  commit;
  logic [MASH_ORDER-1:0] carry;
  logic                  valid_q;
  logic                  adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= 1'b1;
  end

  assign mod_valid = valid_q;
  assign adv       = valid_q && mod_ready;

  fnm_regs #(
    .N_MIN (N_MIN),
    .N_MAX (N_MAX),
    .N_RST (N_RST)
  ) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_sel         (wr_sel),
    .wr_data        (wr_data),
    .n_eff          (n_eff),
    .frac_work      (frac_work),
    .int_clamped    (int_clamped),
    .commit         (commit),
    .ref_div_factor (ref_div_factor),
    .lo_div_log2    (lo_div_log2)
  );

  fnm_mash #(
    .STAGES (MASH_ORDER)
  ) u_mash (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (adv),
    .frac  (frac_work),
    .carry (carry)
  );

  fnm_shaper u_shaper (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .n_eff    (n_eff),
    .carry    (carry),
    .mod_data (mod_data)
  );

  p_valid_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mod_valid |=> mod_valid)
    else $error("valid dropped outside reset");

  p_mod_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mod_valid |-> (({1'b0, mod_data} + 9'd1 >= {1'b0, n_eff}) &&
                   ({1'b0, mod_data} <= {1'b0, n_eff} + 9'd2)))
    else $error("modulus outside N-1..N+2");

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_valid && !mod_ready && !commit) |=> $stable(mod_data))
    else $error("offered modulus changed while stalled");

endmodule

// File: tb/tb_fnm_modulus_ctrl.sv
module tb_fnm_modulus_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int FONE       = 1 << 20;
  localparam int FMASK      = FONE - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       mod_ready = 1'b0;
  logic       mod_valid;
  logic [7:0] mod_data;
  logic       int_clamped;
  logic [1:0] ref_div_factor;
  logic [2:0] lo_div_log2;

  always #(CLK_PERIOD/2) clk = ~clk;

  fnm_modulus_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mod_ready(mod_ready), .mod_valid(mod_valid), .mod_data(mod_data),
    .int_clamped(int_clamped), .ref_div_factor(ref_div_factor), .lo_div_log2(lo_div_log2)
  );

  // behavioural reference state
  int  m_int_sh, m_hi, m_mid, m_nraw, m_frac, m_ref, m_lo, m_acc1, m_acc2, m_c2d;
  bit  m_valid;
  int  vectors = 0;
  int  fails = 0;
  bit  done = 0;
  int  last_seen;
  bit  summing = 0;
  longint win_sum;

  function automatic int neff();
    if (m_nraw < 19) return 19;
    if (m_nraw > 251) return 251;
    return m_nraw;
  endfunction

  function automatic int exp_mod();
    int s1, s2;
    s1 = m_acc1 + m_frac;
    s2 = m_acc2 + (s1 & FMASK);
    return neff() + (s1 >> 20) + (s2 >> 20) - m_c2d;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_int_sh = 19; m_nraw = 19; m_hi = 0; m_mid = 0; m_frac = 0;
    m_ref = 0; m_lo = 0; m_acc1 = 0; m_acc2 = 0; m_c2d = 0; m_valid = 0;
  endtask

  task automatic compare_all();
    if (!rst_n) begin
      chk(mod_valid == 1'b0, "R1 valid in reset", mod_valid, 0);
      return;
    end
    chk(mod_valid == m_valid, "R1 valid", mod_valid, m_valid);
    if (m_valid) begin
      chk(mod_data == exp_mod(), "R4 modulus", mod_data, exp_mod());
      chk((mod_data + 1 >= neff()) && (mod_data <= neff() + 2), "R5 window", mod_data, neff());
    end
    chk(int_clamped == (m_nraw < 19 || m_nraw > 251), "R8 flag", int_clamped,
        (m_nraw < 19 || m_nraw > 251));
    chk(ref_div_factor == ((m_ref == 1) ? 2 : 1), "R9 ref", ref_div_factor, (m_ref == 1) ? 2 : 1);
    chk(lo_div_log2 == 2 + m_lo, "R10 lo", lo_div_log2, 2 + m_lo);
    last_seen = mod_data;
  endtask

  task automatic step(input bit we, input int sel, input int d, input bit rdy);
    int s1, s2;
    wr_en = we; wr_sel = 3'(sel); wr_data = 8'(d); mod_ready = rdy;
    @(posedge clk);
    if (!rst_n) model_reset();
    else begin
      if (m_valid && rdy) begin
        if (summing) win_sum += last_seen;
        s1 = m_acc1 + m_frac;
        s2 = m_acc2 + (s1 & FMASK);
        m_acc1 = s1 & FMASK;
        m_acc2 = s2 & FMASK;
        m_c2d  = s2 >> 20;
      end
      if (we) begin
        case (sel)
          0: m_int_sh = d;
          1: begin m_hi = d & 15; m_ref = (d >> 4) & 3; end
          2: m_mid = d;
          3: begin m_frac = (m_hi << 16) | (m_mid << 8) | d; m_nraw = m_int_sh; end
          4: m_lo = d & 3;
          default: ;
        endcase
      end
      m_valid = 1;
    end
    @(negedge clk);
    wr_en = 1'b0;
    compare_all();
  endtask

  task automatic run(input int n, input bit rdy);
    for (int i = 0; i < n; i++) step(0, 0, 0, rdy);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int hold;
    int lo_before;
    model_reset();
    @(negedge clk);
    // R1: reset state
    run(3, 1);
    chk(mod_valid == 1'b0, "R1 reset", mod_valid, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    chk(mod_valid == 1'b1, "R1 valid after reset", mod_valid, 1);
    chk(mod_data == 19, "R1 modulus after reset", mod_data, 19);
    chk(int_clamped == 0, "R1 flag", int_clamped, 0);
    chk(ref_div_factor == 1, "R1 ref", ref_div_factor, 1);
    chk(lo_div_log2 == 2, "R1 lo", lo_div_log2, 2);

    // R3: partial writes have no effect until the low byte
    step(1, 0, 40, 1);
    step(1, 1, 8'h15, 1);
    chk(ref_div_factor == 2, "R9 immediate ref", ref_div_factor, 2);
    step(1, 2, 8'h33, 1);
    run(4, 1);
    chk(mod_data == 19, "R3 no partial effect", mod_data, 19);
    step(1, 3, 8'h21, 1);
    chk(mod_data >= 39 && mod_data <= 42, "R3 commit", mod_data, 40);
    run(300, 1);

    // R6: back-pressure holds the offered value
    hold = mod_data;
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0);
      chk(mod_data == hold, "R6 stall hold", mod_data, hold);
    end
    for (int i = 0; i < 120; i++) step(0, 0, 0, i[0]);

    // commit while stalled, then other fractions
    step(1, 0, 77, 0);
    step(1, 1, 8'h0F, 0);
    step(1, 2, 8'hFF, 0);
    step(1, 3, 8'hFF, 0);
    run(3, 0);
    run(200, 1);
    step(1, 1, 8'h08, 1);
    step(1, 2, 8'h00, 1);
    step(1, 3, 8'h01, 1);
    run(200, 1);

    // R2: unused codes change nothing
    lo_before = lo_div_log2;
    step(1, 5, 8'hFF, 1);
    step(1, 6, 8'hFF, 1);
    step(1, 7, 8'hFF, 1);
    chk(lo_div_log2 == lo_before, "R2 unused code", lo_div_log2, lo_before);
    chk(ref_div_factor == 1, "R2 unused code ref", ref_div_factor, 1);

    // R8: clamping
    step(1, 0, 5, 1);
    step(1, 3, 0, 1);
    chk(int_clamped == 1, "R8 low flag", int_clamped, 1);
    chk(mod_data >= 18 && mod_data <= 21, "R8 low clamp", mod_data, 19);
    run(20, 1);
    step(1, 0, 255, 1);
    chk(int_clamped == 1, "R8 pending only", int_clamped, 1);
    step(1, 3, 0, 1);
    chk(mod_data >= 250 && mod_data <= 253, "R8 high clamp", mod_data, 251);
    run(20, 1);
    step(1, 0, 251, 1);
    step(1, 3, 0, 1);
    chk(int_clamped == 0, "R8 top in range", int_clamped, 0);
    step(1, 0, 19, 1);
    step(1, 3, 0, 1);
    chk(int_clamped == 0, "R8 bottom in range", int_clamped, 0);
    run(20, 1);

    // R9 / R10: divider selects
    step(1, 1, 8'h20, 1);
    chk(ref_div_factor == 1, "R9 code 10", ref_div_factor, 1);
    step(1, 1, 8'h30, 1);
    chk(ref_div_factor == 1, "R9 code 11", ref_div_factor, 1);
    step(1, 1, 8'h10, 1);
    chk(ref_div_factor == 2, "R9 code 01", ref_div_factor, 2);
    for (int c = 0; c < 4; c++) begin
      step(1, 4, c, 1);
      chk(lo_div_log2 == 2 + c, "R10 lo code", lo_div_log2, 2 + c);
    end

    // R7: mean over a 4096-value window
    rst_n = 1'b0;
    run(2, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    step(1, 0, 100, 0);
    step(1, 1, 8'h01, 0);
    step(1, 2, 8'h23, 0);
    step(1, 3, 8'h00, 0);
    win_sum = 0;
    summing = 1;
    run(4096, 1);
    summing = 0;
    chk((win_sum == 409600 + 291) || (win_sum == 409600 + 292), "R7 window sum",
        int'(win_sum), 409600 + 291);

    done = 1;
    summary();
    $finish;
  end

endmodule